// File: doc/BRIEF.md
# Dual-Role Bus Tenure Controller

This block decides who owns a shared bus. It uses three active-low wires: request, grant and busy. A configuration input selects one of two roles.

In the arbiter role, the block grants the bus either to its own transfer logic or to a single outside master. It watches the shared busy wire to learn when that outside master is finished.

In the requester role, the block drives request and waits for a grant from an outside arbiter. It then claims the bus with busy, runs its transfer and gives the bus back. If the arbiter leaves the grant in place, the block stays parked on the bus and can start its next transfer without requesting again.

Each wire is split into an output value, an output enable (1 = drive) and an input sample. The input sample is the resolved value of the wire. Every output comes from a register clocked on the rising edge, and every input is sampled on that edge. The block has no data path. Its internal side is two plain control pins:
- `xfer_req`, a level held until the transfer is owned.
- `xfer_done`, a pulse in the last owned cycle.

Top module: `bus_tenure_ctl`

## Requirements
- R1: While reset is applied, every wire output value reads 1 (negated) and no wire is driven. After reset the block is an idle non-owner. In arbiter role (`arb_int`=1) it drives grant high. In requester role it drives request high.
- R2: In arbiter role, suppose `xfer_req` is high while the block is idle. Then from the next cycle the block drives busy low, without asserting request.
- R3: Busy stays driven low up to and including the cycle in which `xfer_done` is high. In the cycle after that, busy is driven high. In the cycle after that, busy is not driven.
- R4: In arbiter role, suppose the internal request and the outside request (`br_i` low) are both seen in the same idle cycle. Then the internal side wins. Grant is never driven low while the block itself drives busy low.
- R5: In arbiter role, suppose the block is idle with no internal request and samples `br_i` low. Then from the next cycle it drives grant low.
- R6: Suppose the outside master pulls busy low while it is granted. Then grant is driven high from the next cycle. The block then starts nothing, including internal transfers, until busy reads high again.
- R7: Suppose the outside request returns high before the outside master has pulled busy low. Then grant is driven high from the next cycle and the block is idle.
- R8: In requester role, suppose `xfer_req` is high while the block is idle. Then from the next cycle request is driven low. It stays low until a qualified grant is seen, and is driven high from the first owned cycle.
- R9: A grant counts only when `bg_i` is low and `bb_i` is high at the same edge. A grant seen while busy is low is ignored. In requester role, busy is driven low only in the cycle after a qualified grant.
- R10: In requester role, suppose grant is still low in the cycle in which busy is driven high. Then the block parks: it stops driving request and busy. A new `xfer_req` then leads to busy low on the next cycle, with request never driven low.
- R11: Suppose the grant goes high while the block is parked. Then the block becomes idle and drives request high. A later transfer must request again.
- R12: The role input is sampled only while idle. Changing `arb_int` during a tenure leaves the wire enables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_int | input | 1 | 1 = arbiter role, 0 = requester role |
| xfer_req | input | 1 | Internal transfer wants the bus (level) |
| xfer_done | input | 1 | Last owned cycle of the internal transfer |
| br_i | input | 1 | Resolved request wire, active low |
| bg_i | input | 1 | Resolved grant wire, active low |
| bb_i | input | 1 | Resolved busy wire, active low |
| br_o | output | 1 | Request drive value |
| br_oe | output | 1 | Request drive enable |
| bg_o | output | 1 | Grant drive value |
| bg_oe | output | 1 | Grant drive enable |
| bb_o | output | 1 | Busy drive value |
| bb_oe | output | 1 | Busy drive enable |

## Verification
The assertions check the following on every cycle:
- Grant is never offered while the block itself holds busy.
- Grant is withdrawn one cycle after the outside master claims busy.
- Request and grant are never driven together.
- A requester-role tenure starts only after a qualified grant.
- Busy is always released high for exactly one cycle before it is let go.

Only the directed scenarios can show the rest:
- The priority choice between the two masters.
- The wait for the outside master's busy to clear.
- Entry into parking and exit from it.
- The role input being ignored during a tenure.

These depend on sequences of stimulus rather than on a relation between neighbouring cycles.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_OWN,
    ST_REL,
    ST_XGNT,
    ST_XOWN,
    ST_PARK
  } tenure_st_e;

  typedef struct packed {
    logic br_o;
    logic br_oe;
    logic bg_o;
    logic bg_oe;
    logic bb_o;
    logic bb_oe;
  } pins_t;
endpackage

// File: rtl/bt_fsm.sv
module bt_fsm
  import bus_tenure_pkg::*;
#(
  parameter bit PARK_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arb_int,
  input  logic       xfer_req,
  input  logic       xfer_done,
  input  logic       br_i,
  input  logic       bg_i,
  input  logic       bb_i,
  output tenure_st_e state_d,
  output logic       mode_d,
  output logic       mode_q
);
  tenure_st_e state_q;
  logic park_ok;
  logic qual_gnt;

  generate
    if (PARK_EN) begin : g_park
      assign park_ok = 1'b1;
    end else begin : g_nopark
      assign park_ok = 1'b0;
    end
  endgenerate

  // a grant counts only with busy negated at the same edge
  assign qual_gnt = !bg_i && bb_i;
  assign mode_d   = (state_q == ST_IDLE) ? arb_int : mode_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (arb_int) begin
          if (xfer_req)   state_d = ST_OWN;
          else if (!br_i) state_d = ST_XGNT;
        end else if (xfer_req) begin
          state_d = ST_REQ;
        end
      end
      ST_REQ:  if (qual_gnt) state_d = ST_OWN;
      ST_OWN:  if (xfer_done) state_d = ST_REL;
      ST_REL:  state_d = (!mode_q && park_ok && !bg_i) ? ST_PARK : ST_IDLE;
      ST_XGNT: begin
        if (!bb_i)     state_d = ST_XOWN;
        else if (br_i) state_d = ST_IDLE;
      end
      ST_XOWN: if (bb_i) state_d = ST_IDLE;
      ST_PARK: begin
        if (bg_i)                      state_d = ST_IDLE;
        else if (xfer_req && qual_gnt) state_d = ST_OWN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/bt_pin_drv.sv
module bt_pin_drv
  import bus_tenure_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tenure_st_e state_d,
  input  logic       mode_d,
  output pins_t      pins_q
);
  pins_t pins_d;

  always_comb begin
    // idle defaults: the role picks which wire is held negated
    pins_d = '{br_o: 1'b1, br_oe: !mode_d, bg_o: 1'b1, bg_oe: mode_d,
               bb_o: 1'b1, bb_oe: 1'b0};
    case (state_d)
      ST_REQ: begin
        pins_d.br_o  = 1'b0;
        pins_d.br_oe = 1'b1;
        pins_d.bg_oe = 1'b0;
      end
      ST_OWN: begin
        pins_d.bb_o  = 1'b0;
        pins_d.bb_oe = 1'b1;
      end
      ST_REL:  pins_d.bb_oe = 1'b1;
      ST_XGNT: begin
        pins_d.br_oe = 1'b0;
        pins_d.bg_o  = 1'b0;
        pins_d.bg_oe = 1'b1;
      end
      ST_XOWN: begin
        pins_d.br_oe = 1'b0;
        pins_d.bg_oe = 1'b1;
      end
      ST_PARK: begin
        pins_d.br_oe = 1'b0;
        pins_d.bg_oe = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= '{br_o: 1'b1, br_oe: 1'b0, bg_o: 1'b1, bg_oe: 1'b0,
                           bb_o: 1'b1, bb_oe: 1'b0};
    else        pins_q <= pins_d;
  end
endmodule

// File: rtl/bus_tenure_ctl.sv
module bus_tenure_ctl
  import bus_tenure_pkg::*;
#(
  parameter bit PARK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_int,
  input  logic xfer_req,
  input  logic xfer_done,
  input  logic br_i,
  input  logic bg_i,
  input  logic bb_i,
  output logic br_o,
  output logic br_oe,
  output logic bg_o,
  output logic bg_oe,
  output logic bb_o,
  output logic bb_oe
);
  tenure_st_e state_d;
  logic       mode_d;
  logic       mode_q;
  pins_t      pins_q;

  bt_fsm #(.PARK_EN(PARK_EN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arb_int(arb_int), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .br_i(br_i), .bg_i(bg_i), .bb_i(bb_i),
    .state_d(state_d), .mode_d(mode_d), .mode_q(mode_q)
  );

  bt_pin_drv u_drv (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .mode_d(mode_d),
    .pins_q(pins_q)
  );

  assign br_o  = pins_q.br_o;
  assign br_oe = pins_q.br_oe;
  assign bg_o  = pins_q.bg_o;
  assign bg_oe = pins_q.bg_oe;
  assign bb_o  = pins_q.bb_o;
  assign bb_oe = pins_q.bb_oe;
endmodule

// File: rtl/bus_tenure_chk.sv
module bus_tenure_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_q,
  input logic br_o,
  input logic br_oe,
  input logic bg_o,
  input logic bg_oe,
  input logic bb_o,
  input logic bb_oe,
  input logic bg_i,
  input logic bb_i
);
  logic own_busy;
  assign own_busy = bb_oe && !bb_o;

  a_r4_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    own_busy |-> !(bg_oe && !bg_o));

  a_r6_grant_dropped_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_oe && !bg_o && !bb_i && !bb_oe) |=> bg_o);

  a_r3_release_driven_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(own_busy) && !own_busy) |-> (bb_oe && bb_o));

  a_r3_release_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_oe && bb_o) |=> !bb_oe);

  a_r9_qualified_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && own_busy && !$past(own_busy)) |-> $past(!bg_i && bb_i));

  a_r8_request_off_when_owning: assert property (@(posedge clk) disable iff (!rst_n)
    own_busy |-> !(br_oe && !br_o));

  a_r12_one_role_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_oe && bg_oe));
endmodule

bind bus_tenure_ctl bus_tenure_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .br_o(br_o), .br_oe(br_oe),
  .bg_o(bg_o), .bg_oe(bg_oe), .bb_o(bb_o), .bb_oe(bb_oe), .bg_i(bg_i),
  .bb_i(bb_i)
);

// File: tb/sim_bus_tenure_ctl.sv
`timescale 1ns/1ps
module sim_bus_tenure_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_int = 1'b1, xfer_req = 1'b0, xfer_done = 1'b0;
  logic ext_br = 1'b1, ext_bg = 1'b1, ext_bb = 1'b1;
  logic br_o, br_oe, bg_o, bg_oe, bb_o, bb_oe;
  logic br_i, bg_i, bb_i;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // resolved wires: the block's drive wins when enabled
  assign br_i = br_oe ? br_o : ext_br;
  assign bg_i = bg_oe ? bg_o : ext_bg;
  assign bb_i = bb_oe ? bb_o : ext_bb;

  bus_tenure_ctl u0 (
    .clk(clk), .rst_n(rst_n), .arb_int(arb_int), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .br_i(br_i), .bg_i(bg_i), .bb_i(bb_i),
    .br_o(br_o), .br_oe(br_oe), .bg_o(bg_o), .bg_oe(bg_oe),
    .bb_o(bb_o), .bb_oe(bb_oe)
  );

  // expected pin vectors {br_o,br_oe,bg_o,bg_oe,bb_o,bb_oe}
  localparam logic [5:0] P_OFF   = 6'b101010;
  localparam logic [5:0] I_IDLE  = 6'b101110;
  localparam logic [5:0] I_OWN   = 6'b101101;
  localparam logic [5:0] I_REL   = 6'b101111;
  localparam logic [5:0] I_XGNT  = 6'b100110;
  localparam logic [5:0] E_IDLE  = 6'b111010;
  localparam logic [5:0] E_REQ   = 6'b011010;
  localparam logic [5:0] E_OWN   = 6'b111001;
  localparam logic [5:0] E_REL   = 6'b111011;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {br_o, br_oe, bg_o, bg_oe, bb_o, bb_oe};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pins act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1 during reset", P_OFF);
    rst_n = 1'b1;
    step();
    check("R1 idle arbiter", I_IDLE);
  endtask

  task automatic t_int_own();
    xfer_req = 1'b1; step();
    check("R2 busy low", I_OWN);
    xfer_req = 1'b0; step();
    check("R3 busy held", I_OWN);
    xfer_done = 1'b1; step();
    check("R3 released high", I_REL);
    xfer_done = 1'b0; step();
    check("R3 tristated", I_IDLE);
  endtask

  task automatic t_int_priority();
    xfer_req = 1'b1; ext_br = 1'b0; step();
    check("R4 internal wins", I_OWN);
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    check("R4 release", I_REL);
    xfer_done = 1'b0; step();
    check("R4 idle", I_IDLE);
    step();
    check("R5 grant out", I_XGNT);
    ext_bb = 1'b0; step();
    check("R6 grant dropped", I_IDLE);
    ext_br = 1'b1; xfer_req = 1'b1; step();
    check("R6 waits for busy", I_IDLE);
    ext_bb = 1'b1; step();
    check("R6 idle after tenure", I_IDLE);
    step();
    check("R6 internal after wait", I_OWN);
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    xfer_done = 1'b0; step();
    check("R3 back idle", I_IDLE);
  endtask

  task automatic t_int_withdraw();
    ext_br = 1'b0; step();
    check("R5 grant", I_XGNT);
    ext_br = 1'b1; step();
    check("R7 withdrawn", I_IDLE);
  endtask

  task automatic t_ext_flow();
    arb_int = 1'b0; step();
    check("R12 requester idle", E_IDLE);
    xfer_req = 1'b1; step();
    check("R8 request low", E_REQ);
    step();
    check("R8 request held", E_REQ);
    ext_bg = 1'b0; ext_bb = 1'b0; step();
    check("R9 grant ignored while busy", E_REQ);
    ext_bb = 1'b1; step();
    check("R9 owned after qualified", E_OWN);
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    check("R3 requester release", E_REL);
    xfer_done = 1'b0; step();
    check("R10 parked", P_OFF);
    xfer_req = 1'b1; step();
    check("R10 start from park", E_OWN);
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    xfer_done = 1'b0; ext_bg = 1'b1; step();
    check("R10 no park without grant", E_IDLE);
    xfer_req = 1'b1; step();
    check("R8 requests again", E_REQ);
    ext_bg = 1'b0; step();
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    xfer_done = 1'b0; ext_bg = 1'b1; step();
    check("R8 idle", E_IDLE);
  endtask

  task automatic t_park_drop();
    ext_bg = 1'b0; xfer_req = 1'b1; step();
    check("R11 request first", E_REQ);
    step();
    check("R11 own", E_OWN);
    xfer_req = 1'b0; xfer_done = 1'b1; step();
    xfer_done = 1'b0; step();
    check("R11 parked", P_OFF);
    ext_bg = 1'b1; step();
    check("R11 unparked idle", E_IDLE);
  endtask

  task automatic t_mode_hold();
    arb_int = 1'b1; step();
    check("R12 arbiter idle", I_IDLE);
    xfer_req = 1'b1; step();
    arb_int = 1'b0; xfer_req = 1'b0; step();
    check("R12 role held during tenure", I_OWN);
    xfer_done = 1'b1; step();
    check("R12 release", I_REL);
    xfer_done = 1'b0; arb_int = 1'b1; step();
    check("R12 back idle", I_IDLE);
  endtask

  initial begin
    t_reset();
    t_int_own();
    t_int_priority();
    t_int_withdraw();
    t_ext_flow();
    t_park_drop();
    t_mode_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule